// File: doc/BRIEF.md
# Weighted Camera Field Sequencer

This block decides which camera supplies each field of a time-multiplexed video stream. One sequence cycle holds 50 field slots, one per output field, so at 50 fields per second a cycle lasts one second. The user names one priority camera and how many of the 50 slots it should receive. The other cameras divide the remaining slots equally. Each camera's slots are spread through the cycle instead of being bunched together.

Each pulse on the field-tick input moves the block on by one slot. It then presents the camera number for that slot to the input switching matrix, together with the slot's position in the cycle. The configuration is taken in only when a new cycle begins. A cycle that is already running therefore always finishes with the split it started with.

Top module: `wfs_sequencer`

## Requirements
- R1: While reset is held and directly after it, `camSel` is 0 and `slotIdx` is SLOTS-1 (49). This marks the previous cycle as complete, so the first tick produces slot 0.
- R2: A `fieldTick` sampled high on a rising clock edge updates both outputs on that edge. `slotIdx` goes up by one and wraps from SLOTS-1 (49) to 0.
- R3: With `fieldTick` low, `camSel` and `slotIdx` keep their values.
- R4: In each cycle the camera numbered `prioCam` receives exactly min(`prioShare`, SLOTS) slots.
- R5: The remaining slots R = SLOTS - min(`prioShare`, SLOTS) are split among the other NUM_CAMS-1 cameras. Each gets floor(R/(NUM_CAMS-1)) slots. The first R mod (NUM_CAMS-1) of them, counted in ascending camera number with the priority camera skipped, get one slot more. Example: priority camera 3 with share 16 gives cameras 0,1,2,4,5,6 five slots each and camera 7 four slots.
- R6: Slots are handed out by error accumulation. Every camera keeps an accumulator that is cleared at the start of each cycle. On each slot, every accumulator adds its camera's share. The camera with the largest sum wins the slot, with the lowest number winning a tie. The winner's accumulator is then reduced by SLOTS.
- R7: `prioCam` and `prioShare` are sampled only on the tick that produces slot 0. Changes at any other time have no effect until the next cycle.
- R8: A `prioShare` above SLOTS is treated as SLOTS. The priority camera then fills every slot and the other cameras get none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fieldTick | input | 1 | One-cycle pulse per output field slot |
| prioCam | input | 3 | Number of the priority camera |
| prioShare | input | 6 | Slots per cycle requested for the priority camera |
| camSel | output | 3 | Camera selected for the current slot |
| slotIdx | output | 6 | Position of the current slot in the cycle (0..49) |

## Verification
Two things can happen in the same clock: the cycle wrap, where the tick for slot 0 reloads the shares and clears the accumulators, and a change of configuration. The bench changes `prioCam` and `prioShare` in the middle of a cycle and again just before the wrapping tick. It then checks slot by slot that the running cycle keeps its old sequence and that the new sequence starts exactly at slot 0. The sequences are compared against a model built from the requirements, and the slot totals are counted per camera, including uneven remainders and clamped shares.

// File: rtl/wfs_pkg.sv
package wfs_pkg;

  // Strobes passed from the slot control to the allocation datapath
  typedef struct packed {
    logic advance;     // a field tick was sampled this cycle
    logic cycleStart;  // this tick opens a new sequence cycle
  } wfsStrobe_t;

endpackage

// File: rtl/wfs_ctrl.sv
module wfs_ctrl
  import wfs_pkg::*;
#(
  parameter int SLOTS = 50
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fieldTick,
  output wfsStrobe_t               strobe,
  output logic [$clog2(SLOTS)-1:0] slotIdx
);

  localparam int SLOT_W = $clog2(SLOTS);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

  logic atLast;

  assign atLast            = (slotIdx == LAST_SLOT);
  assign strobe.advance    = fieldTick;
  assign strobe.cycleStart = fieldTick && atLast;

  // Reset parks the counter on the last slot so the first tick opens slot 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slotIdx <= LAST_SLOT;
    end else if (fieldTick) begin
      slotIdx <= atLast ? '0 : slotIdx + SLOT_W'(1);
    end
  end

endmodule

// File: rtl/wfs_datapath.sv
module wfs_datapath
  import wfs_pkg::*;
#(
  parameter int NUM_CAMS = 8,
  parameter int SLOTS    = 50
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  wfsStrobe_t                  strobe,
  input  logic [$clog2(NUM_CAMS)-1:0] prioCam,
  input  logic [$clog2(SLOTS+1)-1:0]  prioShare,
  output logic [$clog2(NUM_CAMS)-1:0] camSel
);

  localparam int CAM_W   = $clog2(NUM_CAMS);
  localparam int SHARE_W = $clog2(SLOTS + 1);
  localparam int ACC_W   = SHARE_W + 2;
  localparam int OTHERS  = NUM_CAMS - 1;
  localparam logic [SHARE_W-1:0]      SLOTS_U = SHARE_W'(SLOTS);
  localparam logic signed [ACC_W-1:0] SLOTS_S = ACC_W'(SLOTS);

  logic [SHARE_W-1:0] prioEff, remSlots, baseShare, extraCnt;
  logic [SHARE_W-1:0] shareNew [NUM_CAMS];
  logic [SHARE_W-1:0] shareQ   [NUM_CAMS];
  logic [SHARE_W-1:0] shareUse [NUM_CAMS];
  logic signed [ACC_W-1:0] accQ   [NUM_CAMS];
  logic signed [ACC_W-1:0] accSum [NUM_CAMS];
  logic signed [ACC_W-1:0] accNxt [NUM_CAMS];
  logic [CAM_W-1:0]        winner;
  logic signed [ACC_W-1:0] bestVal;

  // Share table for a fresh cycle, built from the live configuration
  always_comb begin
    prioEff   = (prioShare > SLOTS_U) ? SLOTS_U : prioShare;
    remSlots  = SLOTS_U - prioEff;
    baseShare = remSlots / SHARE_W'(OTHERS);
    extraCnt  = remSlots % SHARE_W'(OTHERS);
    for (int c = 0; c < NUM_CAMS; c++) begin
      int rank;
      rank = (CAM_W'(c) < prioCam) ? c : c - 1;
      if (CAM_W'(c) == prioCam) begin
        shareNew[c] = prioEff;
      end else begin
        shareNew[c] = baseShare + ((rank < int'(extraCnt)) ? SHARE_W'(1) : '0);
      end
    end
  end

  // Per-camera accumulate step; a new cycle starts from cleared accumulators
  for (genvar g = 0; g < NUM_CAMS; g++) begin : g_acc
    assign shareUse[g] = strobe.cycleStart ? shareNew[g] : shareQ[g];
    assign accSum[g]   = (strobe.cycleStart ? '0 : accQ[g])
                         + $signed({2'b00, shareUse[g]});
    assign accNxt[g]   = accSum[g] - ((winner == CAM_W'(g)) ? SLOTS_S : '0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        accQ[g]   <= '0;
        shareQ[g] <= '0;
      end else if (strobe.advance) begin
        accQ[g] <= accNxt[g];
        if (strobe.cycleStart) shareQ[g] <= shareNew[g];
      end
    end
  end

  // Largest accumulator wins; strict compare keeps the lowest index on ties
  always_comb begin
    winner  = '0;
    bestVal = accSum[0];
    for (int c = 1; c < NUM_CAMS; c++) begin
      if (accSum[c] > bestVal) begin
        winner  = CAM_W'(c);
        bestVal = accSum[c];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      camSel <= '0;
    end else if (strobe.advance) begin
      camSel <= winner;
    end
  end

endmodule

// File: rtl/wfs_sequencer.sv
module wfs_sequencer
  import wfs_pkg::*;
#(
  parameter int NUM_CAMS = 8,
  parameter int SLOTS    = 50
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        fieldTick,
  input  logic [$clog2(NUM_CAMS)-1:0] prioCam,
  input  logic [$clog2(SLOTS+1)-1:0]  prioShare,
  output logic [$clog2(NUM_CAMS)-1:0] camSel,
  output logic [$clog2(SLOTS)-1:0]    slotIdx
);

  wfsStrobe_t strobe;

  wfs_ctrl #(.SLOTS(SLOTS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .fieldTick (fieldTick),
    .strobe    (strobe),
    .slotIdx   (slotIdx)
  );

  wfs_datapath #(.NUM_CAMS(NUM_CAMS), .SLOTS(SLOTS)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .prioCam   (prioCam),
    .prioShare (prioShare),
    .camSel    (camSel)
  );

endmodule

// File: rtl/wfs_sequencer_chk.sv
module wfs_sequencer_chk #(
  parameter int NUM_CAMS = 8,
  parameter int SLOTS    = 50
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        fieldTick,
  input logic [$clog2(NUM_CAMS)-1:0] prioCam,
  input logic [$clog2(SLOTS+1)-1:0]  prioShare,
  input logic [$clog2(NUM_CAMS)-1:0] camSel,
  input logic [$clog2(SLOTS)-1:0]    slotIdx
);

  localparam int CAM_W   = $clog2(NUM_CAMS);
  localparam int SLOT_W  = $clog2(SLOTS);
  localparam int SHARE_W = $clog2(SLOTS + 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

  logic               tickD, haveCyc;
  logic [CAM_W-1:0]   lCam;
  logic [SHARE_W-1:0] lShare, cnt;

  // Tracks how many displayed slots belong to the priority camera of the cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tickD   <= 1'b0;
      haveCyc <= 1'b0;
      lCam    <= '0;
      lShare  <= '0;
      cnt     <= '0;
    end else begin
      tickD <= fieldTick;
      if (fieldTick && slotIdx == LAST_SLOT) begin
        haveCyc <= 1'b1;
        lCam    <= prioCam;
        lShare  <= (prioShare > SHARE_W'(SLOTS)) ? SHARE_W'(SLOTS) : prioShare;
        cnt     <= '0;
      end else if (tickD && camSel == lCam) begin
        cnt <= cnt + SHARE_W'(1);
      end
    end
  end

  p_slot_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    slotIdx <= LAST_SLOT);

  p_slot_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fieldTick |=> slotIdx == (($past(slotIdx) == LAST_SLOT) ? '0 : $past(slotIdx) + SLOT_W'(1)));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !fieldTick |=> ($stable(slotIdx) && $stable(camSel)));

  p_prio_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tickD && haveCyc && slotIdx == LAST_SLOT)
      |-> (int'(cnt) + ((camSel == lCam) ? 1 : 0)) == int'(lShare));

endmodule

bind wfs_sequencer wfs_sequencer_chk #(.NUM_CAMS(NUM_CAMS), .SLOTS(SLOTS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fieldTick (fieldTick),
  .prioCam   (prioCam),
  .prioShare (prioShare),
  .camSel    (camSel),
  .slotIdx   (slotIdx)
);

// File: tb/wfs_sequencer_tb.sv
module wfs_sequencer_tb;

  localparam int NC = 8;
  localparam int NS = 50;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fieldTick = 1'b0;
  logic [2:0] prioCam = '0;
  logic [5:0] prioShare = '0;
  logic [2:0] camSel;
  logic [5:0] slotIdx;

  int testCnt = 0;
  int failCnt = 0;
  int expSeq [NS];
  int expShare [NC];
  int seen [NC];

  always #10 clk = ~clk;

  wfs_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .fieldTick(fieldTick),
    .prioCam(prioCam), .prioShare(prioShare),
    .camSel(camSel), .slotIdx(slotIdx)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Reference split and spread, written from R4, R5, R6 and R8
  task automatic buildExp(input int cam, input int share);
    int acc [NC];
    int eff, rem, base, extra, rank, best;
    eff   = (share > NS) ? NS : share;
    rem   = NS - eff;
    base  = rem / (NC - 1);
    extra = rem % (NC - 1);
    for (int c = 0; c < NC; c++) begin
      rank = (c < cam) ? c : c - 1;
      expShare[c] = (c == cam) ? eff : base + ((rank < extra) ? 1 : 0);
      acc[c] = 0;
    end
    for (int s = 0; s < NS; s++) begin
      for (int c = 0; c < NC; c++) acc[c] += expShare[c];
      best = 0;
      for (int c = 1; c < NC; c++) if (acc[c] > acc[best]) best = c;
      expSeq[s] = best;
      acc[best] -= NS;
    end
  endtask

  task automatic tick();
    @(negedge clk) fieldTick = 1'b1;
    @(negedge clk) fieldTick = 1'b0;
  endtask

  // Tick through slots [from, to) and check each against the reference
  task automatic runSlots(input int from, input int to, input string tag);
    for (int s = from; s < to; s++) begin
      tick();
      check(int'(slotIdx) == s, {tag, " R2 slot index"}, slotIdx, s);
      check(int'(camSel) == expSeq[s], {tag, " R6 camera"}, camSel, expSeq[s]);
      seen[camSel]++;
    end
  endtask

  task automatic clearSeen();
    for (int c = 0; c < NC; c++) seen[c] = 0;
  endtask

  task automatic checkCounts(input string tag);
    for (int c = 0; c < NC; c++)
      check(seen[c] == expShare[c], {tag, " R4/R5 slot total"}, seen[c], expShare[c]);
  endtask

  task automatic t_reset();
    check(camSel == 3'd0, "R1 reset camera", camSel, 0);
    check(slotIdx == 6'd49, "R1 reset slot", slotIdx, 49);
  endtask

  task automatic t_default();
    @(negedge clk) begin prioCam = 3'd0; prioShare = 6'd15; end
    buildExp(0, 15);
    clearSeen();
    runSlots(0, NS, "default");
    checkCounts("default");
    check(expShare[0] == 15 && expShare[1] == 5, "R5 model split", expShare[1], 5);
  endtask

  task automatic t_hold();
    logic [2:0] c0;
    logic [5:0] s0;
    @(negedge clk) begin prioCam = 3'd6; prioShare = 6'd10; end
    buildExp(6, 10);
    clearSeen();
    runSlots(0, 20, "hold");
    c0 = camSel;
    s0 = slotIdx;
    repeat (7) @(negedge clk);
    check(camSel == c0, "R3 camera held", camSel, c0);
    check(slotIdx == s0, "R3 slot held", slotIdx, s0);
    runSlots(20, NS, "hold");
    checkCounts("hold");
  endtask

  task automatic t_uneven();
    @(negedge clk) begin prioCam = 3'd3; prioShare = 6'd16; end
    buildExp(3, 16);
    clearSeen();
    runSlots(0, NS, "uneven");
    checkCounts("uneven");
    check(seen[7] == 4, "R5 last camera short", seen[7], 4);
    check(seen[4] == 5, "R5 skip priority rank", seen[4], 5);
  endtask

  task automatic t_midchange();
    @(negedge clk) begin prioCam = 3'd5; prioShare = 6'd20; end
    buildExp(5, 20);
    clearSeen();
    runSlots(0, 10, "midchange");
    @(negedge clk) begin prioCam = 3'd2; prioShare = 6'd40; end
    runSlots(10, 49, "midchange R7");
    @(negedge clk) begin prioCam = 3'd1; prioShare = 6'd30; end
    runSlots(49, NS, "midchange R7");
    checkCounts("midchange R7");
    // Configuration present at the wrapping tick governs the new cycle
    buildExp(1, 30);
    clearSeen();
    runSlots(0, NS, "reload R7");
    checkCounts("reload R7");
  endtask

  task automatic t_clamp();
    @(negedge clk) begin prioCam = 3'd6; prioShare = 6'd63; end
    buildExp(6, 63);
    clearSeen();
    runSlots(0, NS, "clamp R8");
    check(seen[6] == NS, "R8 priority fills cycle", seen[6], NS);
    @(negedge clk) begin prioCam = 3'd1; prioShare = 6'd0; end
    buildExp(1, 0);
    clearSeen();
    runSlots(0, NS, "zero share R5");
    check(seen[1] == 0, "R4 zero share", seen[1], 0);
    checkCounts("zero share");
  endtask

  initial begin
    #2_000_000;
    failCnt++;
    testCnt++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_default();
    t_hold();
    t_uneven();
    t_midchange();
    t_clamp();
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule